// File: doc/BRIEF.md
# Nested interrupt priority manager

This block holds the current software priority of a small processor core as a two-bit level field and decides, every cycle, whether an interrupt is entered. Each maskable request line carries a two-bit priority level from 0 (lowest) to 3 (highest). A request is taken only when its priority is strictly above the current level. On entry the level field is raised to that priority, so requests of the same or lower priority stay blocked while the handler runs, and higher ones nest on top of it.

The level field uses a non-binary encoding. The instruction sequencer drives single-cycle strobes for the enable, disable, return, pop-flags and software-trap operations, and supplies the flags value restored from the stack. The trap is taken at any level. The "level is 3" output drives the conditional jumps that test whether interrupts are masked.

The priority of a source is frozen at the moment that source is taken. A handler that raises the priority of its own still-pending source is entered again at once. Any other change waits until the request line has dropped and risen again.

Top module: `nest_prio_ctrl`

## Requirements
- R1: After reset the level field is 11, the level-3 flag is high and no entry pulse is given.
- R2: An enable strobe loads 10 (level 0) into the level field and a disable strobe loads 11 (level 3), visible the cycle after the strobe. No interrupt entry happens in that cycle.
- R3: A return or pop-flags strobe loads the supplied stack field into the level field. A return also ends the handler of the most recently entered source.
- R4: The field encodes level 0 as 10, level 1 as 01, level 2 as 00 and level 3 as 11. The level-3 flag is high exactly when the field is 11, and at level 3 no maskable request is entered.
- R5: A maskable request is entered when its priority is strictly above the current level and no control strobe is present. The cycle after, the entry pulse is high for one cycle, the vector equals the source index, and the field holds the encoding of the source priority. A priority-0 source is never entered.
- R6: Among several enterable requests, the highest priority wins. Between equal priorities, the lowest index wins.
- R7: A trap strobe is always taken. The vector is NSRC (4 by default) and the field becomes 11.
- R8: Once a source is taken, its priority is frozen until its request line is seen low. Priority changes in between have no effect. After the line drops and rises again, the new priority applies.
- R9: While a source's handler is active, its request is still high, and its priority is raised above both the frozen value and the current level, the source is entered again. The same vector is given and the field takes the new priority. Lowering the priority has no effect.
- R10: When several strobes arrive in one cycle, precedence is trap, then return, then pop-flags, then disable, then enable. Entry, including re-entry, waits for a cycle without strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NSRC | Pending request lines, one per source |
| prio_i | input | 2*NSRC | Priority level of each source, 2 bits per source, source i at bits 2i+1:2i |
| en_op | input | 1 | Enable strobe (load level 0) |
| dis_op | input | 1 | Disable strobe (load level 3) |
| ret_op | input | 1 | Handler return strobe |
| pop_op | input | 1 | Pop-flags strobe |
| trap_op | input | 1 | Software trap strobe |
| stk_field | input | 2 | Level field restored by return or pop |
| take_pulse | output | 1 | One-cycle interrupt-entry pulse |
| take_vec | output | $clog2(NSRC+1) | Vector taken: source index, or NSRC for the trap |
| lvl_field | output | 2 | Current level field |
| lvl_is3 | output | 1 | High when the level field is 11 |

## Verification
The trap and a maskable entry can compete in the same cycle, and so can a return strobe and a pending request. The bench raises a priority-3 request in the same cycle as the trap strobe. It expects the trap vector first, no entry while the field is 11, and then, after a return lowers the level, the held request entered one cycle late. It also drives a return and a disable together, and a priority raise inside a handler together with a disable strobe. In both cases the bench checks that the strobe wins and that no entry pulse appears.

// File: rtl/nest_prio_ctrl.sv
module nest_prio_ctrl #(
  parameter int NSRC = 4,
  localparam int VW = $clog2(NSRC + 1),
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [2*NSRC-1:0] prio_i,
  input  logic              en_op,
  input  logic              dis_op,
  input  logic              ret_op,
  input  logic              pop_op,
  input  logic              trap_op,
  input  logic [1:0]        stk_field,
  output logic              take_pulse,
  output logic [VW-1:0]     take_vec,
  output logic [1:0]        lvl_field,
  output logic              lvl_is3
);

  // field <-> level mapping is its own inverse
  function automatic logic [1:0] xlat(input logic [1:0] v);
    return {~(v[1] ^ v[0]), v[0]};
  endfunction

  logic [1:0]      lvl_q;
  logic [NSRC-1:0] held;
  logic [1:0]      frz [NSRC];
  logic [1:0]      eff [NSRC];
  logic            svc_v;
  logic [IW-1:0]   svc_i;

  logic [1:0]    rank;
  logic          best_v, re_hit;
  logic [1:0]    best_p, re_p;
  logic [IW-1:0] best_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_eff
    assign eff[g] = held[g] ? frz[g] : prio_i[2*g +: 2];
  end

  assign lvl_field = lvl_q;
  assign lvl_is3   = &lvl_q;

  always_comb begin
    rank   = xlat(lvl_q);
    best_v = 1'b0;
    best_p = 2'd0;
    best_i = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && eff[i] > rank && (!best_v || eff[i] >= best_p)) begin
        best_v = 1'b1;
        best_p = eff[i];
        best_i = IW'(i);
      end
    end
    re_hit = 1'b0;
    re_p   = 2'd0;
    for (int i = 0; i < NSRC; i++) begin
      if (svc_v && svc_i == IW'(i) && held[i] && req_i[i] &&
          prio_i[2*i +: 2] > frz[i] && prio_i[2*i +: 2] > rank) begin
        re_hit = 1'b1;
        re_p   = prio_i[2*i +: 2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q      <= 2'b11;
      take_pulse <= 1'b0;
      take_vec   <= '0;
      held       <= '0;
      svc_v      <= 1'b0;
      svc_i      <= '0;
      for (int i = 0; i < NSRC; i++) frz[i] <= 2'd0;
    end else begin
      take_pulse <= 1'b0;
      held       <= held & req_i;
      if (trap_op) begin
        take_pulse <= 1'b1;
        take_vec   <= VW'(NSRC);
        lvl_q      <= 2'b11;
      end else if (ret_op) begin
        lvl_q <= stk_field;
        svc_v <= 1'b0;
      end else if (pop_op) begin
        lvl_q <= stk_field;
      end else if (dis_op) begin
        lvl_q <= 2'b11;
      end else if (en_op) begin
        lvl_q <= 2'b10;
      end else if (re_hit) begin
        take_pulse <= 1'b1;
        take_vec   <= VW'(svc_i);
        lvl_q      <= xlat(re_p);
        frz[svc_i] <= re_p;
      end else if (best_v) begin
        take_pulse   <= 1'b1;
        take_vec     <= VW'(best_i);
        lvl_q        <= xlat(best_p);
        held[best_i] <= 1'b1;
        frz[best_i]  <= best_p;
        svc_v        <= 1'b1;
        svc_i        <= best_i;
      end
    end
  end

endmodule

// File: rtl/nest_prio_ctrl_chk.sv
module nest_prio_ctrl_chk #(
  parameter int NSRC = 4,
  localparam int VW = $clog2(NSRC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_op,
  input logic          dis_op,
  input logic          ret_op,
  input logic          pop_op,
  input logic          trap_op,
  input logic [1:0]    stk_field,
  input logic          take_pulse,
  input logic [VW-1:0] take_vec,
  input logic [1:0]    lvl_field,
  input logic          lvl_is3
);
  localparam logic [VW-1:0] TRAPV = VW'(NSRC);

  p_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_op |=> take_pulse && take_vec == TRAPV && lvl_field == 2'b11);

  p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_op && !trap_op && !ret_op && !pop_op && !dis_op |=> lvl_field == 2'b10 && !take_pulse);

  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_op && !trap_op && !ret_op && !pop_op |=> lvl_field == 2'b11 && !take_pulse);

  p_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_op || pop_op) && !trap_op |=> lvl_field == $past(stk_field));

  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_is3 |=> !take_pulse || take_vec == TRAPV);

  p_entry_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse && take_vec != TRAPV |-> lvl_field != 2'b10);
endmodule

bind nest_prio_ctrl nest_prio_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_op(en_op), .dis_op(dis_op), .ret_op(ret_op),
  .pop_op(pop_op), .trap_op(trap_op), .stk_field(stk_field),
  .take_pulse(take_pulse), .take_vec(take_vec), .lvl_field(lvl_field),
  .lvl_is3(lvl_is3)
);

// File: tb/tb_nest_prio_ctrl.sv
module tb_nest_prio_ctrl;
  localparam int NSRC = 4;
  localparam int VW = $clog2(NSRC + 1);
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] req_i = '0;
  logic [2*NSRC-1:0] prio_i = '0;
  logic en_op = 0, dis_op = 0, ret_op = 0, pop_op = 0, trap_op = 0;
  logic [1:0] stk_field = 2'b00;
  logic take_pulse;
  logic [VW-1:0] take_vec;
  logic [1:0] lvl_field;
  logic lvl_is3;
  int n_chk = 0, n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  nest_prio_ctrl #(.NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
    .en_op(en_op), .dis_op(dis_op), .ret_op(ret_op), .pop_op(pop_op),
    .trap_op(trap_op), .stk_field(stk_field), .take_pulse(take_pulse),
    .take_vec(take_vec), .lvl_field(lvl_field), .lvl_is3(lvl_is3)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input bit p, input int v, input logic [1:0] f);
    chk(take_pulse == p, {tag, " pulse"}, take_pulse, p);
    if (p) chk(take_vec == VW'(v), {tag, " vector"}, take_vec, v);
    chk(lvl_field == f, {tag, " field"}, lvl_field, f);
    chk(lvl_is3 == (f == 2'b11), {tag, " R4 level3 flag"}, lvl_is3, f == 2'b11);
  endtask

  task automatic set_prio(input int i, input logic [1:0] p);
    prio_i[2*i +: 2] = p;
  endtask

  task automatic tick();
    @(negedge clk);
    {en_op, dis_op, ret_op, pop_op, trap_op} = '0;
  endtask

  task automatic tidy();
    req_i = '0; prio_i = '0;
    dis_op = 1; ret_op = 1; stk_field = 2'b11; tick();
    tick();
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 2'b11);
  endtask

  task automatic t_levels();
    en_op = 1; tick(); expect_out("R2 enable", 0, 0, 2'b10);
    dis_op = 1; tick(); expect_out("R2 disable", 0, 0, 2'b11);
    stk_field = 2'b01; ret_op = 1; tick(); expect_out("R3 return", 0, 0, 2'b01);
    stk_field = 2'b00; pop_op = 1; tick(); expect_out("R3 pop", 0, 0, 2'b00);
    en_op = 1; dis_op = 1; tick(); expect_out("R10 dis over en", 0, 0, 2'b11);
    stk_field = 2'b01; ret_op = 1; dis_op = 1; tick(); expect_out("R10 ret over dis", 0, 0, 2'b01);
    stk_field = 2'b00; pop_op = 1; en_op = 1; tick(); expect_out("R10 pop over en", 0, 0, 2'b00);
    tidy();
  endtask

  task automatic t_take();
    en_op = 1; tick();
    req_i[3] = 1; tick(); expect_out("R5 prio0 ignored", 0, 0, 2'b10);
    req_i[3] = 0; set_prio(2, 2); req_i[2] = 1; tick(); expect_out("R5 entry", 1, 2, 2'b00);
    tick(); expect_out("R5 single pulse", 0, 0, 2'b00);
    set_prio(0, 1); req_i[0] = 1; tick(); expect_out("R5 lower blocked", 0, 0, 2'b00);
    tidy();
  endtask

  task automatic t_tie();
    set_prio(0, 1); set_prio(1, 2); set_prio(2, 1); set_prio(3, 2);
    en_op = 1; tick();
    req_i = 4'b1111; tick(); expect_out("R6 tie low index", 1, 1, 2'b00);
    tick(); expect_out("R6 rest blocked", 0, 0, 2'b00);
    tidy();
    set_prio(0, 1); set_prio(1, 1); set_prio(3, 3);
    en_op = 1; tick();
    req_i = 4'b0011; tick(); expect_out("R6 equal pair", 1, 0, 2'b01);
    req_i[3] = 1; tick(); expect_out("R5 nested higher", 1, 3, 2'b11);
    tidy();
  endtask

  task automatic t_trap();
    en_op = 1; tick();
    set_prio(2, 3); req_i[2] = 1; trap_op = 1; tick(); expect_out("R7 trap beats req", 1, NSRC, 2'b11);
    tick(); expect_out("R4 masked at 3", 0, 0, 2'b11);
    stk_field = 2'b10; ret_op = 1; tick(); expect_out("R10 strobe blocks entry", 0, 0, 2'b10);
    tick(); expect_out("R5 held request taken", 1, 2, 2'b11);
    trap_op = 1; tick(); expect_out("R7 trap at level3", 1, NSRC, 2'b11);
    tidy();
  endtask

  task automatic t_freeze();
    set_prio(0, 1); en_op = 1; tick();
    req_i[0] = 1; tick(); expect_out("R8 entry", 1, 0, 2'b01);
    stk_field = 2'b01; ret_op = 1; tick(); expect_out("R8 return", 0, 0, 2'b01);
    set_prio(0, 3); tick(); expect_out("R8 frozen", 0, 0, 2'b01);
    tick(); expect_out("R8 still frozen", 0, 0, 2'b01);
    req_i[0] = 0; tick(); expect_out("R8 line low", 0, 0, 2'b01);
    req_i[0] = 1; tick(); expect_out("R8 new prio", 1, 0, 2'b11);
    tidy();
  endtask

  task automatic t_reenter();
    set_prio(1, 1); en_op = 1; tick();
    req_i[1] = 1; tick(); expect_out("R9 entry", 1, 1, 2'b01);
    set_prio(1, 0); tick(); expect_out("R9 lower ignored", 0, 0, 2'b01);
    set_prio(1, 2); tick(); expect_out("R9 re-entry", 1, 1, 2'b00);
    tick(); expect_out("R9 once", 0, 0, 2'b00);
    set_prio(1, 3); dis_op = 1; tick(); expect_out("R10 strobe blocks re-entry", 0, 0, 2'b11);
    tick(); expect_out("R9 no re-entry at 3", 0, 0, 2'b11);
    tidy();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_take();
    t_tie();
    t_trap();
    t_freeze();
    t_reenter();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule